// File: doc/BRIEF.md
# Satellite Timed Input Responder

This block sits on a satellite node and answers read requests that arrive from the central controller for the node's timed input channels. It keeps a local timestamp counter. The counter stays at zero until a synchronization word is accepted during link bring-up. From then on it counts up by one every clock cycle.

A read request names one input channel and gives an absolute deadline timestamp. The block then waits on that channel and returns exactly one tagged reply. An event reply carries the timestamp and data of the oldest entry in the channel's input FIFO. An overflow reply reports that the channel's FIFO lost data since the last report. A timeout reply is sent once the local counter reaches the deadline with nothing else to report.

Only one request is handled at a time. The reply stays on the reply port until it is taken, and no new request is accepted before then. Overflow pulses from the FIFOs are latched inside the block, one sticky flag per channel. A flag is cleared only by the reply that reports it.

Top module: `sat_input_responder`

## Requirements
- R1: After reset, `rep_valid` is 0, `req_ready` is 1, `fifo_pop` is all zero, and the timestamp counter holds at 0.
- R2: While no synchronization word has been accepted since reset, the counter holds at 0. When `sync_valid` is high at a clock edge, the counter equals `sync_ts` in the next cycle and then increases by exactly one per cycle.
- R3: A request is taken at a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the edge where the reply is taken with `rep_ready`, and it is high again in the following cycle.
- R4: An event reply has `rep_kind` = 1 and carries `fifo_ts` and `fifo_data` of the requested channel's head entry. It pulses `fifo_pop` for that channel only, for one cycle.
- R5: An event that appears on the requested channel while the block waits produces `rep_valid` one cycle later. Entries on other channels are never popped by that request.
- R6: With no event and no overflow, a timeout reply has `rep_kind` = 2 and `rep_ts` equal to the counter value in the deciding cycle. That value is the deadline itself when the deadline was still ahead at request time. Otherwise it is the first counter value checked.
- R7: If the requested channel has a pending overflow, the reply has `rep_kind` = 3, with `rep_ts` and `rep_data` equal to 0. This takes priority over a waiting event, and no FIFO entry is popped.
- R8: A pulse on `fifo_ovf` sets that channel's sticky overflow. The flag survives requests to other channels and is cleared by its own overflow reply, so the next request to that channel sees events again.
- R9: While `rep_valid` is high and `rep_ready` is low, `rep_valid`, `rep_kind`, `rep_ts` and `rep_data` hold their values.
- R10: If an event is present in the same cycle in which the counter reaches the deadline, the reply is the event, not a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_valid | input | 1 | Synchronization word strobe |
| sync_ts | input | TS_W | Timestamp to load into the counter |
| req_valid | input | 1 | Read request strobe |
| req_ready | output | 1 | Block can take a request |
| req_chan | input | CH_W | Requested channel index |
| req_deadline | input | TS_W | Absolute deadline timestamp |
| rep_valid | output | 1 | Reply present |
| rep_ready | input | 1 | Reply taken |
| rep_kind | output | 2 | 1 event, 2 timeout, 3 overflow |
| rep_ts | output | TS_W | Event or timeout timestamp |
| rep_data | output | DATA_W | Event data |
| fifo_valid | input | NCHAN | Per-channel FIFO not empty |
| fifo_ts | input | NCHAN*TS_W | Per-channel head timestamp, channel i at bits i*TS_W |
| fifo_data | input | NCHAN*DATA_W | Per-channel head data, channel i at bits i*DATA_W |
| fifo_ovf | input | NCHAN | Per-channel overflow pulse |
| fifo_pop | output | NCHAN | Per-channel head consume pulse |

## Verification
The hardest cases to reach are the ones decided in a single exact cycle. One is an event that lands in the very cycle the counter meets the deadline. Another is an event that shows up in the middle of a wait, where the reply must follow one cycle later. The bench loads the counter in the same cycle the request is taken, so the counter value in every later deciding cycle is known exactly. A concurrent process then pushes the event on a counted falling edge. Overflow priority and its clearing are set up by pulsing an overflow onto a channel whose FIFO already holds an entry. Random rounds then mix pushes, overflow pulses, deadlines that have already passed and deadlines still ahead, and random reply back-pressure.

// File: rtl/sir_pkg.sv
package sir_pkg;
  typedef enum logic [1:0] {
    KIND_NONE     = 2'd0,
    KIND_EVENT    = 2'd1,
    KIND_TIMEOUT  = 2'd2,
    KIND_OVERFLOW = 2'd3
  } rep_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_REPLY = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/sir_timebase.sv
module sir_timebase #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sync_valid,
  input  logic [TS_W-1:0] sync_ts,
  output logic [TS_W-1:0] now_ts
);
  logic [TS_W-1:0] now_q;
  logic            loaded_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q    <= '0;
      loaded_q <= 1'b0;
    end else if (sync_valid) begin
      now_q    <= sync_ts;
      loaded_q <= 1'b1;
    end else if (loaded_q) begin
      now_q    <= now_q + TS_W'(1);
    end
  end

  assign now_ts = now_q;

  AST_TS_LOAD: assert property (@(posedge clk) disable iff (rst)
    sync_valid |=> now_q == $past(sync_ts)); // R2
  AST_TS_STEP: assert property (@(posedge clk) disable iff (rst)
    (loaded_q && !sync_valid) |=> now_q == $past(now_q) + TS_W'(1)); // R2
  AST_TS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!loaded_q && !sync_valid) |=> now_q == '0); // R2
endmodule

// File: rtl/sir_ovf_track.sv
module sir_ovf_track #(
  parameter int NCHAN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCHAN-1:0] ovf_in,
  input  logic [NCHAN-1:0] clr,
  output logic [NCHAN-1:0] pend
);
  for (genvar i = 0; i < NCHAN; i++) begin : g_ch
    logic flag_q;
    always_ff @(posedge clk) begin
      if (rst)            flag_q <= 1'b0;
      else if (ovf_in[i]) flag_q <= 1'b1;
      else if (clr[i])    flag_q <= 1'b0;
    end
    assign pend[i] = flag_q;

    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
      (flag_q && !clr[i]) |=> flag_q); // R8
    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
      ovf_in[i] |=> flag_q); // R8
  end
endmodule

// File: rtl/sir_ctrl.sv
module sir_ctrl
  import sir_pkg::*;
#(
  parameter int NCHAN  = 4,
  parameter int TS_W   = 32,
  parameter int DATA_W = 16,
  localparam int CH_W  = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [TS_W-1:0]         now_ts,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [CH_W-1:0]         req_chan,
  input  logic [TS_W-1:0]         req_deadline,
  output logic                    rep_valid,
  input  logic                    rep_ready,
  output logic [1:0]              rep_kind,
  output logic [TS_W-1:0]         rep_ts,
  output logic [DATA_W-1:0]       rep_data,
  input  logic [NCHAN-1:0]        fifo_valid,
  input  logic [NCHAN*TS_W-1:0]   fifo_ts,
  input  logic [NCHAN*DATA_W-1:0] fifo_data,
  input  logic [NCHAN-1:0]        ovf_pend,
  output logic [NCHAN-1:0]        fifo_pop,
  output logic [NCHAN-1:0]        ovf_clr
);
  ctrl_state_e       state_q;
  logic [CH_W-1:0]   chan_q;
  logic [TS_W-1:0]   dl_q;
  logic              rep_valid_q;
  rep_kind_e         rep_kind_q;
  logic [TS_W-1:0]   rep_ts_q;
  logic [DATA_W-1:0] rep_data_q;

  logic              sel_ovf, sel_vld, due;
  logic              take_ovf, take_evt, take_to;
  logic [TS_W-1:0]   sel_ts;
  logic [DATA_W-1:0] sel_data;

  always_comb begin
    sel_ovf  = ovf_pend[chan_q];
    sel_vld  = fifo_valid[chan_q];
    sel_ts   = fifo_ts[int'(chan_q)*TS_W +: TS_W];
    sel_data = fifo_data[int'(chan_q)*DATA_W +: DATA_W];
    due      = now_ts >= dl_q;
    take_ovf = (state_q == ST_WAIT) && sel_ovf;
    take_evt = (state_q == ST_WAIT) && !sel_ovf && sel_vld;
    take_to  = (state_q == ST_WAIT) && !sel_ovf && !sel_vld && due;
    for (int i = 0; i < NCHAN; i++) begin
      fifo_pop[i] = take_evt && (chan_q == CH_W'(i));
      ovf_clr[i]  = take_ovf && (chan_q == CH_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      chan_q      <= '0;
      dl_q        <= '0;
      rep_valid_q <= 1'b0;
      rep_kind_q  <= KIND_NONE;
      rep_ts_q    <= '0;
      rep_data_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            chan_q  <= req_chan;
            dl_q    <= req_deadline;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (take_ovf) begin
            rep_kind_q  <= KIND_OVERFLOW;
            rep_ts_q    <= '0;
            rep_data_q  <= '0;
            rep_valid_q <= 1'b1;
            state_q     <= ST_REPLY;
          end else if (take_evt) begin
            rep_kind_q  <= KIND_EVENT;
            rep_ts_q    <= sel_ts;
            rep_data_q  <= sel_data;
            rep_valid_q <= 1'b1;
            state_q     <= ST_REPLY;
          end else if (take_to) begin
            rep_kind_q  <= KIND_TIMEOUT;
            rep_ts_q    <= now_ts;
            rep_data_q  <= '0;
            rep_valid_q <= 1'b1;
            state_q     <= ST_REPLY;
          end
        end
        ST_REPLY: begin
          if (rep_ready) begin
            rep_valid_q <= 1'b0;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rep_valid = rep_valid_q;
  assign rep_kind  = rep_kind_q;
  assign rep_ts    = rep_ts_q;
  assign rep_data  = rep_data_q;

  AST_REPLY_HELD: assert property (@(posedge clk) disable iff (rst)
    (rep_valid_q && !rep_ready) |=> (rep_valid_q && $stable(rep_kind_q) && $stable(rep_ts_q) && $stable(rep_data_q))); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    rep_valid_q |-> !req_ready); // R3
  AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fifo_pop)); // R4
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    (fifo_pop & ~fifo_valid) == '0); // R5
  AST_OVF_NO_POP: assert property (@(posedge clk) disable iff (rst)
    (fifo_pop & ovf_pend) == '0); // R7
  AST_TIMEOUT_DUE: assert property (@(posedge clk) disable iff (rst)
    (rep_valid_q && rep_kind_q == KIND_TIMEOUT) |-> rep_ts_q >= dl_q); // R6
endmodule

// File: rtl/sat_input_responder.sv
module sat_input_responder #(
  parameter int NCHAN  = 4,
  parameter int TS_W   = 32,
  parameter int DATA_W = 16,
  localparam int CH_W  = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sync_valid,
  input  logic [TS_W-1:0]         sync_ts,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [CH_W-1:0]         req_chan,
  input  logic [TS_W-1:0]         req_deadline,
  output logic                    rep_valid,
  input  logic                    rep_ready,
  output logic [1:0]              rep_kind,
  output logic [TS_W-1:0]         rep_ts,
  output logic [DATA_W-1:0]       rep_data,
  input  logic [NCHAN-1:0]        fifo_valid,
  input  logic [NCHAN*TS_W-1:0]   fifo_ts,
  input  logic [NCHAN*DATA_W-1:0] fifo_data,
  input  logic [NCHAN-1:0]        fifo_ovf,
  output logic [NCHAN-1:0]        fifo_pop
);
  logic [TS_W-1:0]  now_ts;
  logic [NCHAN-1:0] ovf_pend;
  logic [NCHAN-1:0] ovf_clr;

  sir_timebase #(.TS_W(TS_W)) u_timebase (
    .clk        (clk),
    .rst        (rst),
    .sync_valid (sync_valid),
    .sync_ts    (sync_ts),
    .now_ts     (now_ts)
  );

  sir_ovf_track #(.NCHAN(NCHAN)) u_ovf (
    .clk    (clk),
    .rst    (rst),
    .ovf_in (fifo_ovf),
    .clr    (ovf_clr),
    .pend   (ovf_pend)
  );

  sir_ctrl #(.NCHAN(NCHAN), .TS_W(TS_W), .DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .now_ts       (now_ts),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_chan     (req_chan),
    .req_deadline (req_deadline),
    .rep_valid    (rep_valid),
    .rep_ready    (rep_ready),
    .rep_kind     (rep_kind),
    .rep_ts       (rep_ts),
    .rep_data     (rep_data),
    .fifo_valid   (fifo_valid),
    .fifo_ts      (fifo_ts),
    .fifo_data    (fifo_data),
    .ovf_pend     (ovf_pend),
    .fifo_pop     (fifo_pop),
    .ovf_clr      (ovf_clr)
  );
endmodule

// File: tb/sat_input_responder_bench.sv
`timescale 1ns/1ps
module sat_input_responder_bench;
  localparam int NCH = 4;
  localparam int TW  = 32;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_valid = 1'b0;
  logic [TW-1:0] sync_ts = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_chan = '0;
  logic [TW-1:0] req_deadline = '0;
  logic rep_valid;
  logic rep_ready = 1'b0;
  logic [1:0] rep_kind;
  logic [TW-1:0] rep_ts;
  logic [DW-1:0] rep_data;
  logic [NCH-1:0] fifo_valid;
  logic [NCH*TW-1:0] fifo_ts;
  logic [NCH*DW-1:0] fifo_data;
  logic [NCH-1:0] fifo_ovf = '0;
  logic [NCH-1:0] fifo_pop;

  always #2.5 clk = ~clk;

  sat_input_responder u_sat_input_responder (
    .clk(clk), .rst(rst), .sync_valid(sync_valid), .sync_ts(sync_ts),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan),
    .req_deadline(req_deadline), .rep_valid(rep_valid), .rep_ready(rep_ready),
    .rep_kind(rep_kind), .rep_ts(rep_ts), .rep_data(rep_data),
    .fifo_valid(fifo_valid), .fifo_ts(fifo_ts), .fifo_data(fifo_data),
    .fifo_ovf(fifo_ovf), .fifo_pop(fifo_pop)
  );

  // bench FIFO models
  logic [TW-1:0] qts  [NCH][64];
  logic [DW-1:0] qdat [NCH][64];
  logic [31:0]   hd [NCH];
  logic [31:0]   tl [NCH];
  bit            m_ovf [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_q
    assign fifo_valid[g] = hd[g] != tl[g];
    assign fifo_ts[g*TW +: TW]   = qts[g][hd[g][5:0]];
    assign fifo_data[g*DW +: DW] = qdat[g][hd[g][5:0]];
  end

  always @(posedge clk) begin
    for (int i = 0; i < NCH; i++)
      if (rst) hd[i] <= 0;
      else if (fifo_pop[i]) hd[i] <= hd[i] + 1;
  end

  // counter model from R2
  logic [TW-1:0] m_now;
  bit            m_ld;
  int            cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin m_now <= 0; m_ld <= 0; end
    else if (sync_valid) begin m_now <= sync_ts; m_ld <= 1; end
    else if (m_ld) m_now <= m_now + 1;
  end

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic push(input int ch, input logic [TW-1:0] ts, input logic [DW-1:0] d);
    qts[ch][tl[ch][5:0]]  = ts;
    qdat[ch][tl[ch][5:0]] = d;
    tl[ch] = tl[ch] + 1;
  endtask

  task automatic pulse_ovf(input int ch);
    fifo_ovf[ch] = 1'b1;
    @(negedge clk);
    fifo_ovf = '0;
    m_ovf[ch] = 1;
  endtask

  // called at a negedge; returns at a negedge after the reply is taken
  task automatic do_req(input int ch, input logic [TW-1:0] dl,
                        input bit with_sync, input logic [TW-1:0] sv,
                        output logic [1:0] k, output logic [TW-1:0] ts,
                        output logic [DW-1:0] d, output int seen_cyc,
                        output logic [TW-1:0] now_at_req);
    int n;
    now_at_req = m_now;
    check(req_ready == 1'b1, "R3", "ready before request", req_ready, 1);
    if (with_sync) begin sync_valid = 1'b1; sync_ts = sv; end
    req_valid = 1'b1; req_chan = ch[1:0]; req_deadline = dl;
    @(negedge clk);
    sync_valid = 1'b0; req_valid = 1'b0;
    check(req_ready == 1'b0, "R3", "ready low while busy", req_ready, 0);
    n = 0;
    while (!rep_valid && n < 3000) begin @(negedge clk); n++; end
    seen_cyc = cyc;
    if (!rep_valid) check(0, "R3", "no reply", 0, 1);
    k = rep_kind; ts = rep_ts; d = rep_data;
    repeat ($urandom_range(0, 3)) begin
      @(negedge clk);
      check(rep_valid && rep_kind == k && rep_ts == ts && rep_data == d,
            "R9", "reply held", {rep_kind, rep_ts}, {k, ts});
      check(req_ready == 1'b0, "R3", "ready low with reply", req_ready, 0);
    end
    rep_ready = 1'b1;
    @(negedge clk);
    rep_ready = 1'b0;
    check(rep_valid == 1'b0 && req_ready == 1'b1, "R3", "idle after take",
          {rep_valid, req_ready}, 2'b01);
  endtask

  logic [1:0] k;
  logic [TW-1:0] ts, nr;
  logic [DW-1:0] d;
  int sc, pc;

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < NCH; i++) begin tl[i] = 0; m_ovf[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rep_valid == 0, "R1", "rep_valid", rep_valid, 0);
    check(req_ready == 1, "R1", "req_ready", req_ready, 1);
    check(fifo_pop == 0, "R1", "fifo_pop", fifo_pop, 0);

    // R2: counter holds at 0 before sync
    repeat (20) @(negedge clk);
    do_req(0, 0, 0, 0, k, ts, d, sc, nr);
    check(k == 2 && ts == 0, "R2", "pre-sync timeout ts", {k, ts}, {2'd2, 32'd0});

    // R2: load visible in the deciding cycle
    do_req(0, 0, 1, 32'h0000_1000, k, ts, d, sc, nr);
    check(k == 2 && ts == 32'h1000, "R2", "loaded ts", {k, ts}, {2'd2, 32'h1000});

    // R6: future deadline gives exact deadline
    do_req(1, 32'h2000_0005, 1, 32'h2000_0000, k, ts, d, sc, nr);
    check(k == 2 && ts == 32'h2000_0005, "R6", "timeout at deadline", {k, ts}, {2'd2, 32'h2000_0005});

    // R10: event present in the cycle the deadline is reached
    fork
      do_req(2, 32'h3000_0005, 1, 32'h3000_0000, k, ts, d, sc, nr);
      begin repeat (6) @(negedge clk); push(2, 32'h3000_0004, 16'hBEEF); end
    join
    check(k == 1 && ts == 32'h3000_0004 && d == 16'hBEEF, "R10", "event beats deadline",
          {k, ts, d}, {2'd1, 32'h3000_0004, 16'hBEEF});

    // R5: event mid-wait replies one cycle later; R4 pop
    fork
      do_req(3, 32'h4000_0100, 1, 32'h4000_0000, k, ts, d, sc, nr);
      begin repeat (9) @(negedge clk); push(3, 32'h4000_0008, 16'h1234); pc = cyc; end
    join
    check(sc == pc + 1, "R5", "reply latency", sc - pc, 1);
    check(k == 1 && d == 16'h1234, "R4", "event reply", {k, d}, {2'd1, 16'h1234});
    check(hd[3] == tl[3], "R4", "entry popped", hd[3], tl[3]);

    // R5: other channels untouched
    push(0, 32'h11, 16'h0011);
    do_req(1, m_now + 3, 0, 0, k, ts, d, sc, nr);
    check(k == 2, "R5", "other chan ignored kind", k, 2);
    check(hd[0] + 1 == tl[0] && fifo_valid[0], "R5", "other chan not popped", hd[0], tl[0] - 1);

    // R7 / R8: overflow priority and clearing
    pulse_ovf(0);
    do_req(0, m_now + 3, 0, 0, k, ts, d, sc, nr);
    check(k == 3 && ts == 0 && d == 0, "R7", "overflow reply", {k, ts, d}, {2'd3, 32'd0, 16'd0});
    check(hd[0] + 1 == tl[0], "R7", "no pop on overflow", hd[0], tl[0] - 1);
    m_ovf[0] = 0;
    do_req(0, m_now + 3, 0, 0, k, ts, d, sc, nr);
    check(k == 1 && ts == 32'h11, "R8", "cleared after report", {k, ts}, {2'd1, 32'h11});

    pulse_ovf(2);
    do_req(3, m_now + 2, 0, 0, k, ts, d, sc, nr);
    check(k == 2, "R8", "other request leaves flag", k, 2);
    do_req(2, m_now + 2, 0, 0, k, ts, d, sc, nr);
    check(k == 3, "R8", "flag still pending", k, 3);
    m_ovf[2] = 0;

    // random phase
    for (int it = 0; it < 200; it++) begin
      int ch, np;
      logic [1:0] ek;
      logic [TW-1:0] ets, dl;
      logic [DW-1:0] ed;
      logic [31:0] hd_before [NCH];
      np = $urandom_range(0, 2);
      for (int p = 0; p < np; p++) begin
        int c = $urandom_range(0, NCH - 1);
        if (tl[c] - hd[c] < 60) push(c, $urandom, 16'($urandom));
      end
      if ($urandom_range(0, 9) == 0) pulse_ovf($urandom_range(0, NCH - 1));
      ch = $urandom_range(0, NCH - 1);
      dl = m_now + 32'($urandom_range(0, 35)) - 32'd5;
      for (int i = 0; i < NCH; i++) hd_before[i] = hd[i];
      if (m_ovf[ch]) begin ek = 3; ets = 0; ed = 0; end
      else if (hd[ch] != tl[ch]) begin ek = 1; ets = qts[ch][hd[ch][5:0]]; ed = qdat[ch][hd[ch][5:0]]; end
      else begin
        ek = 2; ed = 0;
        ets = (dl <= m_now + 1) ? m_now + 1 : dl;
      end
      do_req(ch, dl, 0, 0, k, ts, d, sc, nr);
      if (ek == 3) m_ovf[ch] = 0;
      check(k == ek && ts == ets && d == ed,
            ek == 1 ? "R4" : (ek == 2 ? "R6" : "R7"), "random reply",
            {k, ts, d}, {ek, ets, ed});
      for (int i = 0; i < NCH; i++) begin
        logic [31:0] exp_hd;
        exp_hd = (i == ch && ek == 1) ? hd_before[i] + 1 : hd_before[i];
        check(hd[i] == exp_hd, "R5", "pop count", hd[i], exp_hd);
      end
      @(negedge clk);
    end
    finish_run();
  end
endmodule